// File: doc/BRIEF.md
# Dual Gated-Clock Serial Shift Register

This block holds two independent serial-in shift registers, eight stages each by default. Each register shifts on the rising edge of its own effective clock. That clock is the logical OR of a per-register clock pin and a clock pin common to both registers. A rising edge on the common pin therefore shifts both registers together. A pin held HIGH masks any edge on the other pin that feeds the same OR. A per-register select input chooses which of two serial data inputs enters the first stage. The last stage of each register drives a true output and a complemented output.

The block runs entirely on one fast system clock. All clock pins are treated as slow asynchronous signals. Each pin passes through a two-flop synchronizer. The OR of the synchronized levels is compared with its value in the previous cycle. One shift happens in the system cycle where that OR goes from LOW to HIGH. The select and data inputs are sampled in that same cycle, so they must be steady around it.

An active-LOW master reset clears all stages of both registers at once, whatever the clocks are doing. After reset is released, any clock level already present is taken as the prior level. Only a fresh LOW-to-HIGH transition of an effective clock causes a shift.

Top module: `dual_gated_shifter`

## Requirements
- R1: While rstN is LOW, every stage is cleared asynchronously (without waiting for a clk edge): qTrue reads 0 and qComp reads 1 on every channel, whatever the clock and data inputs do.
- R2: Each LOW-to-HIGH transition of a channel's effective clock (chClk[c] OR commonClk) moves that channel's contents one stage toward the output. The new serial bit enters stage 0. Stage DEPTH-1 drives the outputs, so a bit appears at qTrue[c] after DEPTH such shifts.
- R3: The serial bit entering channel c equals dLow[c] when sel[c] is 0, and dHigh[c] when sel[c] is 1.
- R4: qComp[c] is always the inverse of qTrue[c].
- R5: While one input of a channel's OR is HIGH, edges on the other input of that OR cause no shift. The falling edge that releases the inhibit causes no shift either.
- R6: When chClk[c] and commonClk rise in the same cycle, channel c shifts exactly once.
- R7: A rising edge on commonClk while both chClk pins are LOW shifts both channels in the same system cycle.
- R8: With SYNC_STAGES = 2, a rising clock pin changes qTrue at the third rising edge of clk after the pin changes. The output is unchanged after the first and second edges.
- R9: A clock pin that is HIGH when rstN is released causes no shift. The first shift after reset needs a new LOW-to-HIGH transition of the effective clock.
- R10: An edge on chClk[c] alone shifts only channel c. The other channel keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all other inputs |
| rstN | input | 1 | Asynchronous active-LOW master reset for both registers |
| chClk | input | NUM_CH | Per-channel clock pins, bit c belongs to channel c |
| commonClk | input | 1 | Clock pin ORed into every channel's effective clock |
| sel | input | NUM_CH | Per-channel data select, 0 picks dLow, 1 picks dHigh |
| dLow | input | NUM_CH | Serial data source taken when sel is 0 |
| dHigh | input | NUM_CH | Serial data source taken when sel is 1 |
| qTrue | output | NUM_CH | Last stage of each channel |
| qComp | output | NUM_CH | Inverse of the last stage of each channel |

## Verification
On every cycle, the assertions check four things. A channel that receives no shift strobe keeps all its stages. A strobe moves every stage up by one and loads the selected data bit. Strobes never occur in two consecutive cycles. The complemented output mirrors the true one. Only the bench scenarios can show the behaviour that involves the clock pins themselves: the OR gating, inhibit by a held-HIGH input, a single shift for coincident edges, a common edge reaching both channels, the three-edge latency, and suppression of the level present at reset release. The bench drives these on the pins and compares the outputs with a reference model after each step.

// File: rtl/dgsr_pkg.sv
package dgsr_pkg;
  // Per-channel command from control to datapath for one system cycle.
  typedef struct packed {
    logic shiftEn;   // shift this channel in the current cycle
    logic serialBit; // bit entering stage 0 when shifting
  } chStrobe_t;
endpackage

// File: rtl/dgsr_sync.sv
module dgsr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/dgsr_ctrl.sv
module dgsr_ctrl
  import dgsr_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CH-1:0]      chClk,
  input  logic                   commonClk,
  input  logic [NUM_CH-1:0]      sel,
  input  logic [NUM_CH-1:0]      dLow,
  input  logic [NUM_CH-1:0]      dHigh,
  output chStrobe_t [NUM_CH-1:0] strobes
);
  // The edge detector is armed once the synchronizers and prevEff hold real pin levels.
  localparam int ARM_LIMIT = SYNC_STAGES + 1;
  localparam int ARM_W     = $clog2(ARM_LIMIT + 1);

  logic [NUM_CH-1:0] chSync;
  logic              commonSync;
  logic [NUM_CH-1:0] effClk;
  logic [NUM_CH-1:0] prevEff;
  logic [ARM_W-1:0]  armCnt;
  logic              armed;

  dgsr_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_chSync (
    .clk(clk), .rstN(rstN), .asyncIn(chClk), .syncOut(chSync)
  );

  dgsr_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_commonSync (
    .clk(clk), .rstN(rstN), .asyncIn(commonClk), .syncOut(commonSync)
  );

  assign effClk = chSync | {NUM_CH{commonSync}};
  assign armed  = (armCnt == ARM_W'(ARM_LIMIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEff <= '0;
      armCnt  <= '0;
    end else begin
      prevEff <= effClk;
      if (!armed) armCnt <= armCnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    always_comb begin
      strobes[c].shiftEn   = armed & effClk[c] & ~prevEff[c];
      strobes[c].serialBit = sel[c] ? dHigh[c] : dLow[c];
    end
  end
endmodule

// File: rtl/dgsr_datapath.sv
module dgsr_datapath
  import dgsr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  chStrobe_t [NUM_CH-1:0]             strobes,
  output logic      [NUM_CH-1:0][DEPTH-1:0]  stages,
  output logic      [NUM_CH-1:0]             qTrue,
  output logic      [NUM_CH-1:0]             qComp
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stages[c] <= '0;
      end else if (strobes[c].shiftEn) begin
        stages[c] <= {stages[c][DEPTH-2:0], strobes[c].serialBit};
      end
    end
    assign qTrue[c] = stages[c][DEPTH-1];
    assign qComp[c] = ~stages[c][DEPTH-1];
  end
endmodule

// File: rtl/dual_gated_shifter.sv
module dual_gated_shifter
  import dgsr_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chClk,
  input  logic              commonClk,
  input  logic [NUM_CH-1:0] sel,
  input  logic [NUM_CH-1:0] dLow,
  input  logic [NUM_CH-1:0] dHigh,
  output logic [NUM_CH-1:0] qTrue,
  output logic [NUM_CH-1:0] qComp
);
  chStrobe_t [NUM_CH-1:0]        strobes;
  logic [NUM_CH-1:0][DEPTH-1:0]  stages;

  dgsr_ctrl #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .chClk(chClk), .commonClk(commonClk),
    .sel(sel), .dLow(dLow), .dHigh(dHigh), .strobes(strobes)
  );

  dgsr_datapath #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .stages(stages),
    .qTrue(qTrue), .qComp(qComp)
  );
endmodule

// File: rtl/dgsr_checker.sv
module dgsr_checker
  import dgsr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 8
) (
  input logic                              clk,
  input logic                              rstN,
  input logic      [NUM_CH-1:0]            sel,
  input logic      [NUM_CH-1:0]            dLow,
  input logic      [NUM_CH-1:0]            dHigh,
  input logic      [NUM_CH-1:0]            qTrue,
  input logic      [NUM_CH-1:0]            qComp,
  input chStrobe_t [NUM_CH-1:0]            strobes,
  input logic      [NUM_CH-1:0][DEPTH-1:0] stages
);
  // R1: outputs sit at the cleared value whenever reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_clear_r1: assert (qTrue == '0 && qComp == '1)
        else $error("reset did not clear the outputs");
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2: contents hold without a strobe
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      !strobes[c].shiftEn |=> $stable(stages[c]));
    // R2: a strobe moves every stage one place toward the output
    p_shift_move_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobes[c].shiftEn |=> stages[c][DEPTH-1:1] == $past(stages[c][DEPTH-2:0]));
    // R3: stage 0 takes the selected port bit
    p_data_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
      strobes[c].shiftEn |=> stages[c][0] == $past(sel[c] ? dHigh[c] : dLow[c]));
    // R4: complemented output mirrors the true one
    p_comp_out_r4: assert property (@(posedge clk) disable iff (!rstN)
      qComp[c] == ~qTrue[c]);
    // R6: one transition of the OR yields a single strobe
    p_single_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobes[c].shiftEn |=> !strobes[c].shiftEn);
  end
endmodule

bind dual_gated_shifter dgsr_checker #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_checker (
  .clk(clk), .rstN(rstN), .sel(sel), .dLow(dLow), .dHigh(dHigh),
  .qTrue(qTrue), .qComp(qComp), .strobes(strobes), .stages(stages)
);

// File: tb/test_dual_gated_shifter.sv
module test_dual_gated_shifter;
  localparam int NCH  = 2;
  localparam int DEP  = 8;
  localparam int HOLD = 5;

  logic           clk = 1'b0;
  logic           rstN;
  logic [NCH-1:0] chClk, sel, dLow, dHigh, qTrue, qComp;
  logic           commonClk;

  logic [DEP-1:0] model [NCH];
  logic [NCH-1:0] pinCh;
  logic           pinCom;
  int             checks = 0;
  int             errors = 0;
  bit             done = 1'b0;

  always #4 clk = ~clk;

  dual_gated_shifter #(.NUM_CH(NCH), .DEPTH(DEP), .SYNC_STAGES(2)) i_dual_gated_shifter (
    .clk(clk), .rstN(rstN), .chClk(chClk), .commonClk(commonClk),
    .sel(sel), .dLow(dLow), .dHigh(dHigh), .qTrue(qTrue), .qComp(qComp)
  );

  function automatic logic pickBit(logic s, logic dl, logic dh);
    return s ? dh : dl; // R3 selection rule
  endfunction

  task automatic checkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int c = 0; c < NCH; c++) begin
      checkBit(tag, qTrue[c], model[c][DEP-1]);
      checkBit({tag, " R4"}, qComp[c], ~model[c][DEP-1]);
    end
  endtask

  task automatic updateModel(logic [NCH-1:0] newCh, logic newCom);
    for (int c = 0; c < NCH; c++) begin
      if (!(pinCh[c] | pinCom) && (newCh[c] | newCom))
        model[c] = {model[c][DEP-2:0], pickBit(sel[c], dLow[c], dHigh[c])};
    end
    pinCh  = newCh;
    pinCom = newCom;
  endtask

  task automatic applyStep(logic [NCH-1:0] newCh, logic newCom,
                           logic [NCH-1:0] s, logic [NCH-1:0] dl,
                           logic [NCH-1:0] dh, string tag);
    @(negedge clk);
    chClk = newCh; commonClk = newCom; sel = s; dLow = dl; dHigh = dh;
    updateModel(newCh, newCom);
    repeat (HOLD) @(negedge clk);
    checkAll(tag);
  endtask

  task automatic clearModel();
    for (int c = 0; c < NCH; c++) model[c] = '0;
    pinCh  = chClk;
    pinCom = commonClk;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic old;
    void'($urandom(32'd7741));
    rstN = 1'b0; chClk = '0; commonClk = 1'b0; sel = '0; dLow = '0; dHigh = '0;
    clearModel();
    repeat (3) @(negedge clk);
    checkAll("R1 reset state");
    rstN = 1'b1;
    repeat (8) @(negedge clk);

    // R7: common clock alone shifts both channels; load 1 then six 0s
    applyStep('0, 1'b1, '0, '1, '0, "R7 common");
    applyStep('0, 1'b0, '0, '1, '0, "R7 common fall");
    for (int i = 0; i < DEP-2; i++) begin
      applyStep('0, 1'b1, '0, '0, '0, "R7 common");
      applyStep('0, 1'b0, '0, '0, '0, "R7 common fall");
    end

    // R8: latency of channel 0 clock pin, R10: channel 1 untouched
    @(negedge clk);
    old = qTrue[0];
    chClk = 2'b01;
    @(negedge clk); checkBit("R8 after edge 1", qTrue[0], old);
    @(negedge clk); checkBit("R8 after edge 2", qTrue[0], old);
    @(negedge clk); checkBit("R8 after edge 3", qTrue[0], model[0][DEP-2]);
    updateModel(2'b01, 1'b0);
    repeat (HOLD) @(negedge clk);
    checkAll("R10 only channel 0");
    applyStep('0, 1'b0, '0, '0, '0, "R2 fall");

    // R6: channel 1 own clock and common rise together
    applyStep(2'b10, 1'b1, '0, '0, '0, "R6 coincident");
    applyStep('0, 1'b0, '0, '0, '0, "R6 fall");

    // R5: common held high masks channel 0 pin edges
    applyStep('0, 1'b0, '0, '1, '0, "R5 prep");
    applyStep('0, 1'b1, '0, '1, '0, "R5 common high");
    applyStep(2'b01, 1'b1, '0, '0, '0, "R5 inhibited rise");
    applyStep('0, 1'b1, '0, '0, '0, "R5 inhibited fall");
    applyStep(2'b11, 1'b1, '0, '1, '1, "R5 inhibited both");
    applyStep(2'b11, 1'b0, '0, '1, '1, "R5 release common");
    applyStep('0, 1'b0, '0, '0, '0, "R5 all low");
    applyStep(2'b01, 1'b0, '1, '0, '1, "R2 R3 after inhibit");

    // Random phase
    for (int i = 0; i < 150; i++) begin
      applyStep(NCH'($urandom), 1'($urandom), NCH'($urandom),
                NCH'($urandom), NCH'($urandom), "R2 R3 R10 random");
    end

    // R1: asynchronous clear between clk edges
    applyStep('1, 1'b1, '1, '1, '1, "R1 prep");
    @(negedge clk);
    #1 rstN = 1'b0;
    #1;
    for (int c = 0; c < NCH; c++) begin
      checkBit("R1 async clear", qTrue[c], 1'b0);
      checkBit("R1 async clear comp", qComp[c], 1'b1);
    end

    // R9: channel 0 pin high across reset release
    chClk = 2'b01; commonClk = 1'b0; sel = '0; dLow = '1; dHigh = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    clearModel();
    repeat (8) @(negedge clk);
    checkAll("R9 no shift on release");
    for (int i = 0; i < DEP-1; i++) begin
      applyStep('0, 1'b0, '0, '0, '0, "R9 fall");
      applyStep(2'b01, 1'b0, '0, '0, '0, "R9 clean shift");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule